// File: doc/BRIEF.md
# PoE Port Power Supervisor

This block supervises the power of one port of power sourcing equipment. It waits in an idle state until a detection-valid strobe arrives, latches the classification result at that moment and enables the port on the next clock. While the port is on, the block compares a sampled load-current code against an overload cutoff on every millisecond tick. The cutoff comes either from the class result (automatic policing) or from a programmed register (manual policing). It removes power when an overload persists. It also removes power when the load draws too little current for too long.

Current is an unsigned code with a 3.2 mA step, and every threshold is compared as a code. In double-power mode the block keeps the low current-limit range selected for a start window after turn-on and then selects the high range. In that mode a severe overload shortens the overload timeout so the pass transistor is not overheated. Each shutoff produces a one-cycle event flag that names its cause. The port then stays off until the next detection-valid strobe.

Top module: `poe_port_supervisor`

## Requirements
- R1: While reset is asserted and after it is released, portEn, limHigh, ovldEvt and discEvt are all 0.
- R2: A detValid pulse while the port is off sets portEn to 1 in the next cycle. A detValid pulse while the port is on has no effect, and the start-window progress is kept.
- R3: In automatic mode (autoPolice=1) the cutoff code follows the class latched at detValid: class 0→109, 1→28, 2→50, 3→109, 4→187. Class codes 5 to 7 use the class 0 cutoff.
- R4: In manual mode (autoPolice=0) the cutoff is progCutoff, and the class result has no effect.
- R5: A tick counts as overloaded when curCode ≥ cutoff or atLimit=1. On the 60th consecutive overloaded tick, portEn drops and ovldEvt is 1 for exactly one cycle. Any tick that is not overloaded restarts the count.
- R6: With dualMode=1 and curCode ≥ 8×cutoff, the overload timeout is 10 ticks instead of 60. With dualMode=0 the timeout stays at 60 ticks.
- R7: limHigh is 1 only while the port is on and dualMode=1, and only from the 60th tick after turn-on.
- R8: A tick counts as undercurrent when curCode ≤ 1 (below 5 mA). On the 350th counted undercurrent tick, portEn drops and discEvt is 1 for exactly one cycle.
- R9: A tick with curCode ≥ 4 (above 10 mA) clears the undercurrent count. A tick with curCode of 2 or 3 leaves the count unchanged.
- R10: After any shutoff the port stays off, and ticks have no effect, until a new detValid pulse.
- R11: ovldEvt and discEvt never assert together. If both timeouts expire on the same tick, only ovldEvt asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-cycle pulse every millisecond |
| detValid | input | 1 | Pulse marking the end of a valid detection and classification |
| classCode | input | 3 | Class result, latched at detValid |
| autoPolice | input | 1 | 1: cutoff taken from the class; 0: cutoff taken from progCutoff |
| progCutoff | input | 10 | Programmed cutoff code, 3.2 mA per step |
| dualMode | input | 1 | Double-power (2x) mode |
| curCode | input | 10 | Sampled load current code, 3.2 mA per step |
| atLimit | input | 1 | Analog current limiter is active |
| portEn | output | 1 | Port power enable |
| limHigh | output | 1 | Selects the high current-limit range |
| ovldEvt | output | 1 | One-cycle pulse on an overload shutoff |
| discEvt | output | 1 | One-cycle pulse on an undercurrent disconnect |

## Verification
The bench sets the current exactly at the cutoff, one step below it, and exactly at and one step below eight times the cutoff. A wrong comparison shows up there as a shutoff that comes one step too early, never comes, or lands at the wrong tick count. It places one good tick in the middle of an overload run, and one hold-level tick or a run of paused ticks in the middle of an undercurrent run. A design that forgets to clear a counter, or clears the wrong one, shuts off early or late. It also lines up both timeouts so they expire on the same tick, re-sends detValid while the port is on, and sends ticks after a shutoff. These cases catch wrong priority, a restarted start window, and a port that turns itself back on.

// File: rtl/poe_sup_pkg.sv
package poe_sup_pkg;
  typedef enum logic {ST_IDLE, ST_ON} supState_t;

  typedef struct packed {
    logic load;
    logic run;
  } ctrlStrobe_t;

  typedef struct packed {
    logic ovTrip;
    logic ucTrip;
  } dpFlags_t;
endpackage

// File: rtl/poe_sup_datapath.sv
module poe_sup_datapath
  import poe_sup_pkg::*;
#(
  parameter int CUR_W       = 10,
  parameter int OVLD_TICKS  = 60,
  parameter int FAST_TICKS  = 10,
  parameter int UC_TICKS    = 350,
  parameter int START_TICKS = 60,
  parameter int HOLD_CODE   = 3,
  parameter int REL_CODE    = 2,
  parameter int FAST_SHIFT  = 3,
  parameter int CUT_C0      = 109,
  parameter int CUT_C1      = 28,
  parameter int CUT_C2      = 50,
  parameter int CUT_C3      = 109,
  parameter int CUT_C4      = 187
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        classCode,
  input  logic              autoPolice,
  input  logic [CUR_W-1:0]  progCutoff,
  input  logic              dualMode,
  input  logic [CUR_W-1:0]  curCode,
  input  logic              atLimit,
  output dpFlags_t          flags,
  output logic              startDone
);
  localparam int OV_W  = $clog2(OVLD_TICKS + 1);
  localparam int UC_W  = $clog2(UC_TICKS + 1);
  localparam int ST_W  = $clog2(START_TICKS + 1);
  localparam int EXT_W = CUR_W + FAST_SHIFT;

  logic [2:0]       classQ;
  logic [CUR_W-1:0] cutoff;
  logic [CUR_W-1:0] classCut [8];
  logic             overload, extreme, under, holdOk;
  logic [OV_W-1:0]  ovCnt;
  logic [OV_W:0]    ovNext, ovLimit;
  logic [UC_W-1:0]  ucCnt;
  logic [UC_W:0]    ucNext;
  logic [ST_W-1:0]  stCnt;

  // Class cutoff table; codes above 4 fall back to class 0
  for (genvar c = 0; c < 8; c++) begin : g_cut
    localparam int CV = (c == 1) ? CUT_C1 : (c == 2) ? CUT_C2 :
                        (c == 3) ? CUT_C3 : (c == 4) ? CUT_C4 : CUT_C0;
    assign classCut[c] = CUR_W'(CV);
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            classQ <= '0;
    else if (strobe.load) classQ <= classCode;

  always_comb begin
    cutoff   = autoPolice ? classCut[classQ] : progCutoff;
    overload = (curCode >= cutoff) || atLimit;
    extreme  = dualMode &&
               ({{FAST_SHIFT{1'b0}}, curCode} >= ({{FAST_SHIFT{1'b0}}, cutoff} << FAST_SHIFT));
    ovLimit  = extreme ? (OV_W+1)'(FAST_TICKS) : (OV_W+1)'(OVLD_TICKS);
    ovNext   = {1'b0, ovCnt} + 1'b1;
    under    = curCode < CUR_W'(REL_CODE);
    holdOk   = curCode > CUR_W'(HOLD_CODE);
    ucNext   = {1'b0, ucCnt} + 1'b1;
    flags.ovTrip = strobe.run && msTick && overload && (ovNext >= ovLimit);
    flags.ucTrip = strobe.run && msTick && under && (ucNext >= (UC_W+1)'(UC_TICKS));
    startDone    = stCnt >= ST_W'(START_TICKS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovCnt <= '0;
      ucCnt <= '0;
      stCnt <= '0;
    end else if (!strobe.run) begin
      ovCnt <= '0;
      ucCnt <= '0;
      stCnt <= '0;
    end else if (msTick) begin
      ovCnt <= overload ? ovNext[OV_W-1:0] : '0;
      if (holdOk)     ucCnt <= '0;
      else if (under) ucCnt <= ucNext[UC_W-1:0];
      if (!startDone) stCnt <= stCnt + 1'b1;
    end
  end

  logic unusedExt;
  assign unusedExt = ^EXT_W;
endmodule

// File: rtl/poe_sup_ctrl.sv
module poe_sup_ctrl
  import poe_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        detValid,
  input  logic        dualMode,
  input  dpFlags_t    flags,
  input  logic        startDone,
  output ctrlStrobe_t strobe,
  output logic        portEn,
  output logic        limHigh,
  output logic        ovldEvt,
  output logic        discEvt
);
  supState_t state;

  always_comb begin
    strobe.load = (state == ST_IDLE) && detValid;
    strobe.run  = (state == ST_ON);
    portEn      = (state == ST_ON);
    limHigh     = portEn && dualMode && startDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ovldEvt <= 1'b0;
      discEvt <= 1'b0;
    end else begin
      ovldEvt <= 1'b0;
      discEvt <= 1'b0;
      unique case (state)
        ST_IDLE: if (detValid) state <= ST_ON;
        ST_ON: begin
          if (flags.ovTrip) begin
            state   <= ST_IDLE;
            ovldEvt <= 1'b1;
          end else if (flags.ucTrip) begin
            state   <= ST_IDLE;
            discEvt <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/poe_port_supervisor.sv
module poe_port_supervisor
  import poe_sup_pkg::*;
#(
  parameter int CUR_W       = 10,
  parameter int OVLD_TICKS  = 60,
  parameter int FAST_TICKS  = 10,
  parameter int UC_TICKS    = 350,
  parameter int START_TICKS = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             detValid,
  input  logic [2:0]       classCode,
  input  logic             autoPolice,
  input  logic [CUR_W-1:0] progCutoff,
  input  logic             dualMode,
  input  logic [CUR_W-1:0] curCode,
  input  logic             atLimit,
  output logic             portEn,
  output logic             limHigh,
  output logic             ovldEvt,
  output logic             discEvt
);
  ctrlStrobe_t strobe;
  dpFlags_t    flags;
  logic        startDone;

  poe_sup_datapath #(
    .CUR_W(CUR_W), .OVLD_TICKS(OVLD_TICKS), .FAST_TICKS(FAST_TICKS),
    .UC_TICKS(UC_TICKS), .START_TICKS(START_TICKS)
  ) dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .strobe(strobe),
    .classCode(classCode), .autoPolice(autoPolice), .progCutoff(progCutoff),
    .dualMode(dualMode), .curCode(curCode), .atLimit(atLimit),
    .flags(flags), .startDone(startDone)
  );

  poe_sup_ctrl ctl (
    .clk(clk), .rstN(rstN), .detValid(detValid), .dualMode(dualMode),
    .flags(flags), .startDone(startDone), .strobe(strobe),
    .portEn(portEn), .limHigh(limHigh), .ovldEvt(ovldEvt), .discEvt(discEvt)
  );
endmodule

// File: rtl/poe_sup_checker.sv
module poe_sup_checker (
  input logic clk,
  input logic rstN,
  input logic detValid,
  input logic dualMode,
  input logic portEn,
  input logic limHigh,
  input logic ovldEvt,
  input logic discEvt
);
  // R2
  turn_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (detValid && !portEn) |=> portEn);

  // R5
  ovld_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovldEvt |=> !ovldEvt);

  // R8
  disc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    discEvt |=> !discEvt);

  // R10
  off_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(portEn) |-> (ovldEvt || discEvt));

  // R10
  evt_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovldEvt || discEvt) |-> !portEn);

  // R11
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovldEvt && discEvt));

  // R7
  lim_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    limHigh |-> (portEn && dualMode));
endmodule

bind poe_port_supervisor poe_sup_checker chk (
  .clk(clk), .rstN(rstN), .detValid(detValid), .dualMode(dualMode),
  .portEn(portEn), .limHigh(limHigh), .ovldEvt(ovldEvt), .discEvt(discEvt)
);

// File: tb/poe_port_supervisor_test.sv
`timescale 1ns/1ps
module poe_port_supervisor_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       detValid = 1'b0;
  logic [2:0] classCode = '0;
  logic       autoPolice = 1'b1;
  logic [9:0] progCutoff = '0;
  logic       dualMode = 1'b0;
  logic [9:0] curCode = '0;
  logic       atLimit = 1'b0;
  logic       portEn, limHigh, ovldEvt, discEvt;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  poe_port_supervisor uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .detValid(detValid),
    .classCode(classCode), .autoPolice(autoPolice), .progCutoff(progCutoff),
    .dualMode(dualMode), .curCode(curCode), .atLimit(atLimit),
    .portEn(portEn), .limHigh(limHigh), .ovldEvt(ovldEvt), .discEvt(discEvt)
  );

  typedef struct packed {
    logic       autoP;
    logic [2:0] cls;
    logic [9:0] prog;
    logic       dual;
    logic [9:0] cur;
    logic       lim;
    logic [9:0] expTick;   // 0: no shutoff within the cap
    logic       expOv;     // 1: overload, 0: disconnect
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 10'd0,   1'b0, 10'd109, 1'b0, 10'd60,  1'b1}, // R3 R5 class0 at cutoff
    '{1'b1, 3'd0, 10'd0,   1'b0, 10'd108, 1'b0, 10'd0,   1'b0}, // R3 one below
    '{1'b1, 3'd1, 10'd0,   1'b0, 10'd30,  1'b0, 10'd60,  1'b1}, // R3 class1
    '{1'b1, 3'd2, 10'd0,   1'b0, 10'd50,  1'b0, 10'd60,  1'b1}, // R3 class2
    '{1'b1, 3'd4, 10'd0,   1'b0, 10'd200, 1'b0, 10'd60,  1'b1}, // R3 class4
    '{1'b1, 3'd4, 10'd0,   1'b0, 10'd186, 1'b0, 10'd0,   1'b0}, // R3 class4 below
    '{1'b1, 3'd6, 10'd0,   1'b0, 10'd109, 1'b0, 10'd60,  1'b1}, // R3 class6 as class0
    '{1'b0, 3'd4, 10'd20,  1'b0, 10'd25,  1'b0, 10'd60,  1'b1}, // R4 manual low
    '{1'b0, 3'd1, 10'd300, 1'b0, 10'd200, 1'b0, 10'd0,   1'b0}, // R4 class ignored
    '{1'b1, 3'd1, 10'd0,   1'b1, 10'd224, 1'b0, 10'd10,  1'b1}, // R6 extreme
    '{1'b1, 3'd1, 10'd0,   1'b1, 10'd223, 1'b0, 10'd60,  1'b1}, // R6 just below
    '{1'b1, 3'd1, 10'd0,   1'b0, 10'd224, 1'b0, 10'd60,  1'b1}, // R6 single mode
    '{1'b1, 3'd0, 10'd0,   1'b0, 10'd50,  1'b1, 10'd60,  1'b1}, // R5 at limit
    '{1'b1, 3'd0, 10'd0,   1'b0, 10'd0,   1'b0, 10'd350, 1'b0}, // R8 zero load
    '{1'b1, 3'd0, 10'd0,   1'b0, 10'd2,   1'b0, 10'd0,   1'b0}  // R9 paused band
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    detValid = 1'b0; msTick = 1'b0;
    @(negedge clk);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic startPort();
    @(negedge clk) detValid = 1'b1;
    @(negedge clk) detValid = 1'b0;
  endtask

  // Applies up to n ticks; stops at the first event. at = tick index of it.
  task automatic runTicks(input int n, output int at, output logic wasOv);
    at = 0; wasOv = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
      if (ovldEvt || discEvt) begin
        at = i; wasOv = ovldEvt;
        if (ovldEvt && discEvt) at = -1;
        break;
      end
    end
  endtask

  initial begin
    #900000;
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int at;
    logic ov;
    // R1 during and after reset
    #1;
    check(!portEn && !limHigh && !ovldEvt && !discEvt, "R1 in reset", portEn, 0);
    doReset();
    check(!portEn && !limHigh && !ovldEvt && !discEvt, "R1 after reset", portEn, 0);

    for (int v = 0; v < NV; v++) begin
      doReset();
      autoPolice = VECS[v].autoP; classCode = VECS[v].cls;
      progCutoff = VECS[v].prog;  dualMode = VECS[v].dual;
      curCode = VECS[v].cur;      atLimit = VECS[v].lim;
      startPort();
      check(portEn == 1'b1, $sformatf("R2 vec%0d on", v), portEn, 1);
      classCode = 3'd3;  // R4/R3: class changes after latch must not matter
      runTicks(VECS[v].expTick == 0 ? 400 : VECS[v].expTick, at, ov);
      check(at == int'(VECS[v].expTick), $sformatf("R5 R8 vec%0d tick", v),
            at, VECS[v].expTick);
      if (VECS[v].expTick != 0) begin
        check(ov == VECS[v].expOv && !portEn, $sformatf("R5 R8 vec%0d cause", v),
              ov, VECS[v].expOv);
        @(negedge clk);
        check(!ovldEvt && !discEvt, $sformatf("R5 vec%0d one cycle", v),
              ovldEvt | discEvt, 0);
      end
    end

    // R7 start window in double mode, R2 repeat detValid ignored
    doReset();
    autoPolice = 1'b1; classCode = 3'd0; dualMode = 1'b1; curCode = 10'd10; atLimit = 1'b0;
    startPort();
    runTicks(59, at, ov);
    check(portEn && !limHigh, "R7 before window", limHigh, 0);
    runTicks(1, at, ov);
    check(limHigh == 1'b1, "R7 after window", limHigh, 1);
    startPort();
    check(portEn && limHigh, "R2 repeat detValid", limHigh, 1);

    // R5 a good tick restarts the overload count
    curCode = 10'd109;
    runTicks(30, at, ov);
    curCode = 10'd10;
    runTicks(1, at, ov);
    curCode = 10'd109;
    runTicks(59, at, ov);
    check(at == 0 && portEn, "R5 count restarted", at, 0);
    runTicks(1, at, ov);
    check(at == 1 && ov && !portEn, "R5 trip after restart", at, 1);

    // R10 port stays off and ticks do nothing
    curCode = 10'd0;
    runTicks(400, at, ov);
    check(at == 0 && !portEn, "R10 idle ignores ticks", portEn, 0);

    // R9 pause band, R7 single mode keeps limHigh low
    dualMode = 1'b0;
    startPort();
    runTicks(200, at, ov);
    check(!limHigh, "R7 single mode", limHigh, 0);
    curCode = 10'd2;
    runTicks(100, at, ov);
    curCode = 10'd0;
    runTicks(149, at, ov);
    check(at == 0 && portEn, "R9 pause holds count", at, 0);
    runTicks(1, at, ov);
    check(at == 1 && !ov && !portEn, "R8 R9 disconnect after pause", at, 1);

    // R9 hold-level tick clears the count
    startPort();
    runTicks(200, at, ov);
    curCode = 10'd4;
    runTicks(1, at, ov);
    curCode = 10'd0;
    runTicks(349, at, ov);
    check(at == 0 && portEn, "R9 cleared by hold level", at, 0);
    runTicks(1, at, ov);
    check(at == 1 && !ov, "R8 disconnect after clear", at, 1);

    // R11 both timeouts on the same tick
    autoPolice = 1'b0; progCutoff = 10'd500; curCode = 10'd0;
    startPort();
    runTicks(290, at, ov);
    progCutoff = 10'd0;
    runTicks(60, at, ov);
    check(at == 60 && ov, "R11 overload wins", at, 60);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule